// File: doc/BRIEF.md
# Timer Configuration Register Bank with Enable Lock

This block holds the configuration of a timer/counter and hands it to the counter core on plain output wires. Software reaches it through a simple synchronous register port. Each write carries an address and a full data word. A read strobe returns the addressed word one cycle later. The counter, the waveform logic and the fault logic sit outside this block and only consume what it exports.

Most configuration is locked while the timer runs. The control register mixes two kinds of bit. Standby, enable and software reset are always live. Clock division, division sync and per-channel capture are locked. When the timer is stopped, a single write can load the locked fields and start the timer at once. When the timer is running, a write that stops it still leaves the locked fields alone. The count direction lives in its own bit, reached through a set address and a clear address, and is never locked.

A write of 1 to the software reset bit returns every register to zero at that write's clock edge.

Top module: `tmrCfgBank`

## Requirements
- R1: After reset every register reads 0 and every configuration output is 0.
- R2: Writes to the fault words (addresses 8 and 9), the waveform extension word (address 3), the driver word (address 4) and the event word (address 5) take effect only while the enable bit is 0. While it is 1, such a write leaves the register and its output unchanged.
- R3: In the control word (address 0), enable (bit 1) and run-in-standby (bit 6) are updated by every control write, whatever the enable state.
- R4: A control write made while enable is 0 loads the prescaler (bits 10:8), the sync mode (bits 13:12) and the capture enables (bits 16 up, one per channel). This holds when the same write sets enable to 1.
- R5: A control write made while enable is 1 leaves the prescaler, sync mode and capture enables unchanged. This holds when the same write clears enable.
- R6: Writing a word with bit 0 set to the direction-set address (1) selects down-counting. Writing it to the direction-clear address (2) selects up-counting. A 0 in bit 0 changes nothing, and the enable state never blocks these writes.
- R7: Reads of address 1 and address 2 both return the current direction in bit 0, where 1 means down.
- R8: A control write with bit 0 set resets every register, enable and direction included, to 0. Bit 0 of the control word always reads 0.
- R9: Read data appears one cycle after the read strobe and reads 0 otherwise. Unmapped addresses read 0, and writes to them change nothing.
- R10: The driver word holds one output-inversion bit per channel in bits NUM_CH-1:0. Every configuration output shows its register's new value right after the accepted write's clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| busAddr | input | ADDR_W | Word address |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | DATA_W | Write data |
| busRdEn | input | 1 | Read strobe |
| busRdData | output | DATA_W | Read data, valid the cycle after busRdEn |
| cfgEnable | output | 1 | Timer enabled |
| cfgRunStandby | output | 1 | Keep running in standby |
| cfgPrescaler | output | 3 | Clock division select |
| cfgPrescSync | output | 2 | Counter/prescaler sync mode |
| cfgCaptureEn | output | NUM_CH | Per-channel capture enable |
| cfgDirDown | output | 1 | 1 = count down |
| cfgFault | output | NUM_FAULT*FAULT_W | Fault control words, word 0 lowest |
| cfgWaveExt | output | WAVE_W | Waveform extension control |
| cfgInvert | output | NUM_CH | Per-channel output inversion |
| cfgEvent | output | EVT_W | Event control |

## Verification
A write lands on the clock edge that samples its strobe, so every configuration output is checked at the falling edge right after that write edge. Read data sits one register stage later. The driver task queues the expected word when it raises the read strobe. The monitor pops that word at the falling edge after the read edge and compares it, so each comparison happens in exactly the cycle the data is due. Each locked case first writes a new value and only then reads the register back, so a wrongly accepted write would show.

// File: rtl/tmrcfg_pkg.sv
package tmrcfg_pkg;
  // Word addresses
  localparam int ADR_CTL    = 0;
  localparam int ADR_DIRSET = 1;
  localparam int ADR_DIRCLR = 2;
  localparam int ADR_WAVEXT = 3;
  localparam int ADR_DRV    = 4;
  localparam int ADR_EVT    = 5;
  localparam int ADR_FAULT0 = 8;

  // Control word layout
  localparam int BIT_SWRST = 0;
  localparam int BIT_EN    = 1;
  localparam int BIT_STBY  = 6;
  localparam int PSC_LSB   = 8;
  localparam int PSC_W     = 3;
  localparam int SYNC_LSB  = 12;
  localparam int SYNC_W    = 2;
  localparam int CAP_LSB   = 16;

  typedef enum logic [2:0] {
    RD_NONE, RD_CTL, RD_DIR, RD_FAULT, RD_WAVEXT, RD_DRV, RD_EVT
  } rdSel_e;

  typedef struct packed {
    logic wrCtl;
    logic wrDirSet;
    logic wrDirClr;
    logic wrFault;
    logic wrWaveExt;
    logic wrDrv;
    logic wrEvt;
    logic softReset;
    logic protOk;
    logic rdEn;
  } strobe_t;
endpackage

// File: rtl/tmrCfgCtrl.sv
module tmrCfgCtrl
  import tmrcfg_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int NUM_FAULT = 2,
  parameter int FSEL_W    = 1
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busSwrBit,
  input  logic              busRdEn,
  input  logic              enableQ,
  output strobe_t           stb,
  output logic [FSEL_W-1:0] faultSel,
  output rdSel_e            rdSel
);
  logic faultHit;

  always_comb begin
    faultHit = 1'b0;
    faultSel = '0;
    for (int i = 0; i < NUM_FAULT; i++) begin
      if (busAddr == ADDR_W'(ADR_FAULT0 + i)) begin
        faultHit = 1'b1;
        faultSel = FSEL_W'(i);
      end
    end
  end

  always_comb begin
    stb       = '0;
    rdSel     = RD_NONE;
    stb.rdEn  = busRdEn;
    // Lock decision uses the enable value held before this write
    stb.protOk = !enableQ;
    if (busAddr == ADDR_W'(ADR_CTL)) begin
      rdSel     = RD_CTL;
      stb.wrCtl = busWrEn;
    end else if (busAddr == ADDR_W'(ADR_DIRSET)) begin
      rdSel        = RD_DIR;
      stb.wrDirSet = busWrEn;
    end else if (busAddr == ADDR_W'(ADR_DIRCLR)) begin
      rdSel        = RD_DIR;
      stb.wrDirClr = busWrEn;
    end else if (busAddr == ADDR_W'(ADR_WAVEXT)) begin
      rdSel         = RD_WAVEXT;
      stb.wrWaveExt = busWrEn;
    end else if (busAddr == ADDR_W'(ADR_DRV)) begin
      rdSel     = RD_DRV;
      stb.wrDrv = busWrEn;
    end else if (busAddr == ADDR_W'(ADR_EVT)) begin
      rdSel     = RD_EVT;
      stb.wrEvt = busWrEn;
    end else if (faultHit) begin
      rdSel       = RD_FAULT;
      stb.wrFault = busWrEn;
    end
    stb.softReset = stb.wrCtl && busSwrBit;
  end

  // R9: a write never lands in more than one register
  always_comb begin
    assert_single_target_R9: assert ($onehot0({stb.wrCtl, stb.wrDirSet, stb.wrDirClr,
      stb.wrFault, stb.wrWaveExt, stb.wrDrv, stb.wrEvt}));
  end
endmodule

// File: rtl/tmrCfgData.sv
module tmrCfgData
  import tmrcfg_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int NUM_CH    = 4,
  parameter int NUM_FAULT = 2,
  parameter int FAULT_W   = 16,
  parameter int FSEL_W    = 1,
  parameter int WAVE_W    = 16,
  parameter int EVT_W     = 16
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  strobe_t                      stb,
  input  logic [FSEL_W-1:0]            faultSel,
  input  rdSel_e                       rdSel,
  input  logic [DATA_W-1:0]            wrData,
  output logic                         enableQ,
  output logic                         stbyQ,
  output logic [PSC_W-1:0]             prescQ,
  output logic [SYNC_W-1:0]            syncQ,
  output logic [NUM_CH-1:0]            capQ,
  output logic                         dirQ,
  output logic [NUM_FAULT*FAULT_W-1:0] faultFlat,
  output logic [WAVE_W-1:0]            waveQ,
  output logic [NUM_CH-1:0]            invertQ,
  output logic [EVT_W-1:0]             evtQ,
  output logic [DATA_W-1:0]            rdData
);
  logic [NUM_FAULT-1:0][FAULT_W-1:0] faultQ;
  logic [DATA_W-1:0] rdNext;

  assign faultFlat = faultQ;

  // Control word: live bits always, locked bits only while stopped
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enableQ <= 1'b0;
      stbyQ   <= 1'b0;
      prescQ  <= '0;
      syncQ   <= '0;
      capQ    <= '0;
    end else if (stb.softReset) begin
      enableQ <= 1'b0;
      stbyQ   <= 1'b0;
      prescQ  <= '0;
      syncQ   <= '0;
      capQ    <= '0;
    end else if (stb.wrCtl) begin
      enableQ <= wrData[BIT_EN];
      stbyQ   <= wrData[BIT_STBY];
      if (stb.protOk) begin
        prescQ <= wrData[PSC_LSB +: PSC_W];
        syncQ  <= wrData[SYNC_LSB +: SYNC_W];
        capQ   <= wrData[CAP_LSB +: NUM_CH];
      end
    end
  end

  // Direction: set/clear pair, never locked
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                           dirQ <= 1'b0;
    else if (stb.softReset)              dirQ <= 1'b0;
    else if (stb.wrDirSet && wrData[0])  dirQ <= 1'b1;
    else if (stb.wrDirClr && wrData[0])  dirQ <= 1'b0;
  end

  // Locked whole-word registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      waveQ   <= '0;
      invertQ <= '0;
      evtQ    <= '0;
    end else if (stb.softReset) begin
      waveQ   <= '0;
      invertQ <= '0;
      evtQ    <= '0;
    end else if (stb.protOk) begin
      if (stb.wrWaveExt) waveQ   <= wrData[WAVE_W-1:0];
      if (stb.wrDrv)     invertQ <= wrData[NUM_CH-1:0];
      if (stb.wrEvt)     evtQ    <= wrData[EVT_W-1:0];
    end
  end

  for (genvar g = 0; g < NUM_FAULT; g++) begin : gFault
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        faultQ[g] <= '0;
      else if (stb.softReset)
        faultQ[g] <= '0;
      else if (stb.wrFault && stb.protOk && (faultSel == FSEL_W'(g)))
        faultQ[g] <= wrData[FAULT_W-1:0];
    end
  end

  always_comb begin
    rdNext = '0;
    unique case (rdSel)
      RD_CTL: begin
        rdNext[BIT_EN]               = enableQ;
        rdNext[BIT_STBY]             = stbyQ;
        rdNext[PSC_LSB +: PSC_W]     = prescQ;
        rdNext[SYNC_LSB +: SYNC_W]   = syncQ;
        rdNext[CAP_LSB +: NUM_CH]    = capQ;
      end
      RD_DIR:    rdNext[0]            = dirQ;
      RD_FAULT:  rdNext[FAULT_W-1:0]  = faultQ[faultSel];
      RD_WAVEXT: rdNext[WAVE_W-1:0]   = waveQ;
      RD_DRV:    rdNext[NUM_CH-1:0]   = invertQ;
      RD_EVT:    rdNext[EVT_W-1:0]    = evtQ;
      default:   rdNext               = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdData <= '0;
    else       rdData <= stb.rdEn ? rdNext : '0;
  end

  assert_locked_drv_R2: assert property (@(posedge clk) disable iff (!rstN)
    (enableQ && stb.wrDrv) |=> $stable(invertQ));

  assert_open_ctl_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!enableQ && stb.wrCtl && !stb.softReset) |=> (prescQ == $past(wrData[PSC_LSB +: PSC_W])));

  assert_locked_ctl_R5: assert property (@(posedge clk) disable iff (!rstN)
    (enableQ && stb.wrCtl && !stb.softReset) |=>
      ($stable(prescQ) && $stable(syncQ) && $stable(capQ)));

  assert_dir_set_R6: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrDirSet && wrData[0]) |=> dirQ);

  assert_soft_reset_R8: assert property (@(posedge clk) disable iff (!rstN)
    stb.softReset |=> (!enableQ && !dirQ && invertQ == '0 && prescQ == '0));
endmodule

// File: rtl/tmrCfgBank.sv
module tmrCfgBank
  import tmrcfg_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 32,
  parameter int NUM_CH    = 4,
  parameter int NUM_FAULT = 2,
  parameter int FAULT_W   = 16,
  parameter int WAVE_W    = 16,
  parameter int EVT_W     = 16
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [ADDR_W-1:0]            busAddr,
  input  logic                         busWrEn,
  input  logic [DATA_W-1:0]            busWrData,
  input  logic                         busRdEn,
  output logic [DATA_W-1:0]            busRdData,
  output logic                         cfgEnable,
  output logic                         cfgRunStandby,
  output logic [2:0]                   cfgPrescaler,
  output logic [1:0]                   cfgPrescSync,
  output logic [NUM_CH-1:0]            cfgCaptureEn,
  output logic                         cfgDirDown,
  output logic [NUM_FAULT*FAULT_W-1:0] cfgFault,
  output logic [WAVE_W-1:0]            cfgWaveExt,
  output logic [NUM_CH-1:0]            cfgInvert,
  output logic [EVT_W-1:0]             cfgEvent
);
  localparam int FSEL_W = (NUM_FAULT > 1) ? $clog2(NUM_FAULT) : 1;

  strobe_t           stb;
  rdSel_e            rdSel;
  logic [FSEL_W-1:0] faultSel;

  tmrCfgCtrl #(.ADDR_W(ADDR_W), .NUM_FAULT(NUM_FAULT), .FSEL_W(FSEL_W)) ctrl_i (
    .busAddr  (busAddr),
    .busWrEn  (busWrEn),
    .busSwrBit(busWrData[BIT_SWRST]),
    .busRdEn  (busRdEn),
    .enableQ  (cfgEnable),
    .stb      (stb),
    .faultSel (faultSel),
    .rdSel    (rdSel)
  );

  tmrCfgData #(
    .DATA_W(DATA_W), .NUM_CH(NUM_CH), .NUM_FAULT(NUM_FAULT), .FAULT_W(FAULT_W),
    .FSEL_W(FSEL_W), .WAVE_W(WAVE_W), .EVT_W(EVT_W)
  ) data_i (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .faultSel (faultSel),
    .rdSel    (rdSel),
    .wrData   (busWrData),
    .enableQ  (cfgEnable),
    .stbyQ    (cfgRunStandby),
    .prescQ   (cfgPrescaler),
    .syncQ    (cfgPrescSync),
    .capQ     (cfgCaptureEn),
    .dirQ     (cfgDirDown),
    .faultFlat(cfgFault),
    .waveQ    (cfgWaveExt),
    .invertQ  (cfgInvert),
    .evtQ     (cfgEvent),
    .rdData   (busRdData)
  );
endmodule

// File: tb/tmrCfgBank_tb_top.sv
module tmrCfgBank_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic        busRdEn = 1'b0;
  logic [31:0] busRdData;
  logic        cfgEnable, cfgRunStandby, cfgDirDown;
  logic [2:0]  cfgPrescaler;
  logic [1:0]  cfgPrescSync;
  logic [3:0]  cfgCaptureEn, cfgInvert;
  logic [31:0] cfgFault;
  logic [15:0] cfgWaveExt, cfgEvent;

  int checkCnt = 0;
  int failCnt  = 0;
  logic rdPending = 1'b0;
  logic [31:0] expQ[$];
  string tagQ[$];

  always #10 clk = ~clk;

  tmrCfgBank dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdEn(busRdEn), .busRdData(busRdData),
    .cfgEnable(cfgEnable), .cfgRunStandby(cfgRunStandby), .cfgPrescaler(cfgPrescaler),
    .cfgPrescSync(cfgPrescSync), .cfgCaptureEn(cfgCaptureEn), .cfgDirDown(cfgDirDown),
    .cfgFault(cfgFault), .cfgWaveExt(cfgWaveExt), .cfgInvert(cfgInvert), .cfgEvent(cfgEvent)
  );

  // Monitor: read data is due one edge after the strobe
  always @(posedge clk) rdPending <= busRdEn;

  always @(negedge clk) begin
    if (rdPending) begin
      checkCnt++;
      if (expQ.size() == 0) begin
        failCnt++;
        $display("FAIL R9 unexpected read data: actual %h expected none", busRdData);
      end else begin
        logic [31:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        if (busRdData !== e) begin
          failCnt++;
          $display("FAIL %s: actual %h expected %h", t, busRdData, e);
        end
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1; busRdEn = 1'b0;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    busAddr = a; busRdEn = 1'b1; busWrEn = 1'b0;
    expQ.push_back(e);
    tagQ.push_back(t);
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  task automatic chk(input logic [31:0] act, input logic [31:0] e, input string t);
    checkCnt++;
    if (act !== e) begin
      failCnt++;
      $display("FAIL %s: actual %h expected %h", t, act, e);
    end
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checkCnt, failCnt);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    chk(32'(cfgEnable), 0, "R1 enable after reset");
    chk(cfgFault, 0, "R1 fault outputs after reset");
    rd(4'd0, 32'h0, "R1 control reads 0");
    rd(4'd4, 32'h0, "R1 driver reads 0");
    rd(4'd1, 32'h0, "R1 direction reads 0");

    // R2 / R10 writes while stopped
    wr(4'd4, 32'h5);
    chk(32'(cfgInvert), 32'h5, "R10 inversion output");
    rd(4'd4, 32'h5, "R10 driver readback");
    wr(4'd8, 32'h1234);
    wr(4'd9, 32'hBEEF);
    wr(4'd3, 32'h00A5);
    wr(4'd5, 32'h0F0F);
    chk(cfgFault, 32'hBEEF1234, "R2 fault outputs");
    rd(4'd8, 32'h1234, "R2 fault0 readback");
    rd(4'd9, 32'hBEEF, "R2 fault1 readback");
    rd(4'd3, 32'h00A5, "R2 wave ext readback");
    rd(4'd5, 32'h0F0F, "R2 event readback");

    // R4 enabling write carries locked fields
    wr(4'd0, 32'h000A2342);
    chk(32'(cfgPrescaler), 3, "R4 prescaler loaded with enable");
    chk(32'(cfgCaptureEn), 32'hA, "R4 capture loaded with enable");
    rd(4'd0, 32'h000A2342, "R4 control readback");

    // R2 locked while running
    wr(4'd4, 32'hF);
    chk(32'(cfgInvert), 32'h5, "R2 driver locked output");
    rd(4'd4, 32'h5, "R2 driver locked readback");
    wr(4'd5, 32'h0);
    rd(4'd5, 32'h0F0F, "R2 event locked readback");
    wr(4'd8, 32'hFFFF);
    rd(4'd8, 32'h1234, "R2 fault locked readback");

    // R3 / R5 live bits change, locked stay
    wr(4'd0, 32'h00000702);
    chk(32'(cfgRunStandby), 0, "R3 standby cleared while running");
    rd(4'd0, 32'h000A2302, "R5 locked control kept");
    wr(4'd0, 32'h0);
    chk(32'(cfgEnable), 0, "R3 enable cleared");
    chk(32'(cfgPrescSync), 2, "R5 sync kept on disabling write");
    rd(4'd0, 32'h000A2300, "R5 control after disable");

    // R2 open again
    wr(4'd4, 32'h9);
    rd(4'd4, 32'h9, "R2 driver after disable");

    // R6 / R7 direction, with timer running
    wr(4'd0, 32'h2);
    rd(4'd0, 32'h2, "R4 enabling write loads zeros");
    wr(4'd1, 32'h1);
    chk(32'(cfgDirDown), 1, "R6 set while running");
    rd(4'd1, 32'h1, "R7 set address reads direction");
    rd(4'd2, 32'h1, "R7 clear address reads direction");
    wr(4'd2, 32'h0);
    chk(32'(cfgDirDown), 1, "R6 clear with bit0=0 no effect");
    wr(4'd2, 32'h1);
    chk(32'(cfgDirDown), 0, "R6 clear while running");
    wr(4'd1, 32'hFFFE);
    chk(32'(cfgDirDown), 0, "R6 set with bit0=0 no effect");
    rd(4'd2, 32'h0, "R7 direction up");
    wr(4'd1, 32'h1);

    // R9 unmapped
    wr(4'd15, 32'hFFFFFFFF);
    rd(4'd15, 32'h0, "R9 unmapped reads 0");
    rd(4'd6, 32'h0, "R9 hole reads 0");
    rd(4'd0, 32'h2, "R9 unmapped write left control");

    // R8 software reset while running
    wr(4'd0, 32'h00000043);
    chk(32'(cfgEnable), 0, "R8 enable cleared");
    chk(32'(cfgDirDown), 0, "R8 direction cleared");
    chk(32'(cfgInvert), 0, "R8 driver cleared");
    rd(4'd0, 32'h0, "R8 control reads 0");
    rd(4'd9, 32'h0, "R8 fault1 cleared");
    rd(4'd5, 32'h0, "R8 event cleared");

    repeat (3) @(negedge clk);
    chk(32'(expQ.size()), 0, "R9 all reads returned");
    finishRun();
  end
endmodule